// File: doc/BRIEF.md
# DV Frame-Aligned Isochronous Receive Filter

This block sits on the receive side of an isochronous channel. Packets arrive as a stream of 32-bit quadlets, and a start-of-packet flag marks the first quadlet of each one. The block can drop the two leading header quadlets of every payload. When frame alignment is switched on, it also holds back payload until a digital-video start-of-frame packet arrives, so that each frame-sized buffer downstream begins on a frame boundary.

A frame-start packet is recognised from a byte pattern in its third quadlet. If a frame start appears while the current buffer is partly filled, the block raises a one-cycle branch request, and the descriptor logic uses it to move to a new buffer. The buffer length, the header mode and the descriptor fill mode are inputs. The two enable bits sit in a small register with separate set and clear write addresses. That register accepts writes only while the context is neither active nor running.

Top module: `dvf_rx_filter`

## Requirements
- R1: A packet is a frame start only if its third quadlet (index 2 from the start-of-packet quadlet) has bits 31:24 equal to 8'h1F and bits 19:16 equal to 4'h7, with bits 23:20 ignored. A packet shorter than three quadlets is never a frame start.
- R2: When enable bit 0 (strip) is 1 and `hdr_mode` is 0, the first two quadlets of every packet are dropped and the rest are forwarded. A packet of two quadlets or fewer forwards nothing.
- R3: When `hdr_mode` is 1, every input quadlet is forwarded unchanged, whatever the enable bits hold.
- R4: Enable bit 1 (sync) takes effect only when strip is in effect and `fill_mode` equals 2'b01. Otherwise the block behaves as in R2 or R3.
- R5: While sync is in effect, every packet is discarded until the first frame-start packet. Forwarding begins with that packet's third quadlet, and every later packet is then forwarded as in R2.
- R6: While sync is in effect, forwarded quadlets are counted modulo `frame_len`. A frame start is in place when the count is 0, and it raises no branch request. Turning sync off clears the alignment and the count.
- R7: A frame start that arrives while the count is not 0 raises `branch_req` for exactly one cycle, together with the output of its third quadlet. The count then restarts with that packet.
- R8: A write with `reg_addr`=0 sets the enable bits where `reg_wdata` is 1. A write with `reg_addr`=1 clears them. `reg_rdata` returns the enables in bits 1:0, reads 0 after reset, and always reads 0 in bits 31:2.
- R9: A register write is ignored while `ctx_active` or `ctx_run` is 1.
- R10: Outputs are registered. A quadlet accepted at one clock edge appears at the next, and `out_valid` and `branch_req` stay low in the cycle after a cycle with no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input quadlet valid |
| in_sop | input | 1 | Input quadlet is the first of a packet |
| in_data | input | 32 | Input quadlet, big-endian byte order |
| hdr_mode | input | 1 | Context keeps headers; 1 forces pass-through |
| fill_mode | input | 2 | Descriptor fill mode; 2'b01 is buffer fill |
| frame_len | input | 16 | Frame buffer length in quadlets |
| ctx_active | input | 1 | Context active status |
| ctx_run | input | 1 | Context run status |
| reg_wr | input | 1 | Enable register write strobe |
| reg_addr | input | 1 | 0 = set address, 1 = clear address |
| reg_wdata | input | 2 | Bit mask for the set or clear write |
| reg_rdata | output | 32 | Enable register read value |
| out_valid | output | 1 | Forwarded quadlet valid |
| out_data | output | 32 | Forwarded quadlet |
| branch_req | output | 1 | One-cycle request to jump to a new frame buffer |

## Verification
The hardest state to reach is an aligned stream in which a frame start lands part-way through a buffer. Reaching it takes the right enables, buffer-fill mode, a first frame start to gain alignment, and then a second frame start before the count wraps. A directed sequence builds this state with a short buffer length and counts the branch pulses. Random traffic then mixes packet lengths from one to seven quadlets, frame-start patterns with a random don't-care nibble, and idle gaps. It also changes configuration at random, including writes attempted while the context is busy. A bench model predicts every output cycle.

// File: rtl/dvf_pkg.sv
`timescale 1ns/1ps
package dvf_pkg;
    localparam int EN_W     = 2;
    localparam int EN_STRIP = 0;
    localparam int EN_SYNC  = 1;
    localparam logic [1:0] FILL_BUFFER = 2'b01;
    localparam logic [7:0] SOF_BYTE0   = 8'h1F;
    localparam logic [3:0] SOF_NIBBLE  = 4'h7;

    // Per-packet stream state: quadlet index (saturating), forward decision, alignment
    typedef struct packed {
        logic [1:0] idx;
        logic       fwd;
        logic       synced;
    } pkt_state_t;
endpackage

// File: rtl/dvf_sof_detect.sv
`timescale 1ns/1ps
module dvf_sof_detect
    import dvf_pkg::*;
(
    input  logic [15:0] hi_half,
    output logic        is_sof
);
    // First byte must match fully; only the low nibble of the second byte matters
    assign is_sof = (hi_half[15:8] == SOF_BYTE0) && (hi_half[3:0] == SOF_NIBBLE);
endmodule

// File: rtl/dvf_enable_reg.sv
`timescale 1ns/1ps
module dvf_enable_reg
    import dvf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [EN_W-1:0]   wdata,
    input  logic              active,
    input  logic              run,
    output logic [EN_W-1:0]   en,
    output logic [DATA_W-1:0] rdata
);
    logic [EN_W-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr && !active && !run) begin
            en_d = addr ? (en_q & ~wdata) : (en_q | wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    for (genvar g = 0; g < DATA_W; g++) begin : g_rd
        if (g < EN_W) begin : g_live
            assign rdata[g] = en_q[g];
        end else begin : g_rsvd
            assign rdata[g] = 1'b0;
        end
    end
endmodule

// File: rtl/dvf_rx_filter.sv
`timescale 1ns/1ps
module dvf_rx_filter
    import dvf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              hdr_mode,
    input  logic [1:0]        fill_mode,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic              ctx_active,
    input  logic              ctx_run,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [EN_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              branch_req
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        pkt_state_t        pkt;
        logic [CNT_W-1:0]  cnt;
        logic              ov;
        logic [DATA_W-1:0] od;
        logic              br;
    } regs_t;

    regs_t r_d, r_q;
    logic [EN_W-1:0] en;
    logic            sof;
    logic            strip_on, sync_on;
    logic [1:0]      idx;
    logic            fwd;
    logic [CNT_W-1:0] base, nxt;

    dvf_enable_reg #(.DATA_W(DATA_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .active(ctx_active), .run(ctx_run), .en(en), .rdata(reg_rdata)
    );

    dvf_sof_detect u_sof (
        .hi_half(in_data[DATA_W-1 -: 16]),
        .is_sof(sof)
    );

    assign strip_on = en[EN_STRIP] & ~hdr_mode;
    assign sync_on  = strip_on & en[EN_SYNC] & (fill_mode == FILL_BUFFER);

    always_comb begin
        r_d  = r_q;
        r_d.ov = 1'b0;
        r_d.br = 1'b0;
        idx  = in_sop ? 2'd0 : r_q.pkt.idx;
        fwd  = 1'b0;
        base = r_q.cnt;
        nxt  = '0;
        if (!sync_on) begin
            r_d.pkt.synced = 1'b0;
            r_d.cnt        = '0;
        end
        if (in_valid) begin
            r_d.pkt.idx = (idx == 2'd3) ? 2'd3 : idx + 2'd1;
            if (!strip_on) begin
                fwd = 1'b1;
            end else if (idx == 2'd2) begin
                fwd = !sync_on || r_q.pkt.synced || sof;
                r_d.pkt.fwd = fwd;
                if (sync_on && sof) begin
                    r_d.br         = r_q.pkt.synced && (r_q.cnt != '0);
                    r_d.pkt.synced = 1'b1;
                    base           = '0;
                end
            end else if (idx == 2'd3) begin
                fwd = r_q.pkt.fwd;
            end
            if (fwd) begin
                r_d.ov = 1'b1;
                r_d.od = in_data;
            end
            if (fwd && sync_on) begin
                nxt      = base + CNT_ONE;
                r_d.cnt  = (nxt == frame_len) ? '0 : nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid  = r_q.ov;
    assign out_data   = r_q.od;
    assign branch_req = r_q.br;
endmodule

// File: rtl/dvf_rx_filter_chk.sv
`timescale 1ns/1ps
module dvf_rx_filter_chk
    import dvf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic [DATA_W-1:0] in_data,
    input logic              hdr_mode,
    input logic              ctx_active,
    input logic              ctx_run,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              branch_req
);
    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_mode && in_valid) |=> (out_valid && out_data == $past(in_data)));

    assert_strip_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !hdr_mode && reg_rdata[EN_STRIP]) |=> !out_valid);

    assert_branch_on_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_req |-> (out_valid && out_data[DATA_W-1 -: 8] == SOF_BYTE0));

    assert_branch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_req |=> !branch_req);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !branch_req));

    assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (ctx_active || ctx_run)) |=> $stable(reg_rdata));

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:EN_W] == '0);
endmodule

bind dvf_rx_filter dvf_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .hdr_mode(hdr_mode), .ctx_active(ctx_active), .ctx_run(ctx_run), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_data(out_data), .branch_req(branch_req)
);

// File: tb/dvf_rx_filter_test.sv
`timescale 1ns/1ps
module dvf_rx_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [31:0] in_data = '0;
    logic        hdr_mode = 1'b0;
    logic [1:0]  fill_mode = 2'b00;
    logic [15:0] frame_len = 16'd6;
    logic        ctx_active = 1'b0, ctx_run = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [1:0]  reg_wdata = '0;
    logic [31:0] reg_rdata, out_data;
    logic        out_valid, branch_req;

    int n_chk = 0, n_bad = 0, n_br = 0;
    bit done = 0;

    // model state
    logic [1:0]  m_en = '0;
    int          m_idx = 0;
    bit          m_fwd = 0, m_sync = 0;
    int          m_cnt = 0;

    dvf_rx_filter uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_fs(input logic [31:0] d);
        return d[31:24] == 8'h1F && d[19:16] == 4'h7;
    endfunction

    // One cycle: drive at negedge, predict, check after the edge
    task automatic step(input bit v, input bit sop, input logic [31:0] d, input string tag);
        bit strip, sync, f, br;
        int idx;
        @(negedge clk);
        in_valid = v; in_sop = sop; in_data = d;
        strip = m_en[0] && !hdr_mode;
        sync  = strip && m_en[1] && fill_mode == 2'b01;
        f = 0; br = 0;
        if (!sync) begin m_sync = 0; m_cnt = 0; end
        if (v) begin
            idx = sop ? 0 : m_idx;
            m_idx = (idx >= 3) ? 3 : idx + 1;
            if (!strip) f = 1;
            else if (idx == 2) begin
                f = !sync || m_sync || is_fs(d);
                if (sync && is_fs(d)) begin
                    br = m_sync && m_cnt != 0;
                    m_cnt = 0;
                    m_sync = 1;
                end
                m_fwd = f;
            end else if (idx == 3) f = m_fwd;
            if (f && sync) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == int'(frame_len)) m_cnt = 0;
            end
        end
        @(posedge clk); #1;
        in_valid = 0;
        chk(out_valid == f, {tag, " valid"}, {31'd0, out_valid}, {31'd0, f});
        if (f) chk(out_data == d, {tag, " data"}, out_data, d);
        chk(branch_req == br, "R7 branch", {31'd0, branch_req}, {31'd0, br});
        if (branch_req) n_br++;
    endtask

    task automatic send_pkt(input int len, input bit fs, input string tag);
        logic [31:0] d;
        for (int i = 0; i < len; i++) begin
            d = $urandom;
            if (i == 2 && fs) d = {8'h1F, 4'($urandom), 4'h7, 16'($urandom)};
            if (i == 2 && !fs && is_fs(d)) d[24] = 1'b0;
            step(1'b1, i == 0, d, tag);
        end
    endtask

    task automatic reg_write(input bit addr, input logic [1:0] m, input bit act, input bit run);
        @(negedge clk);
        reg_wr = 1; reg_addr = addr; reg_wdata = m; ctx_active = act; ctx_run = run;
        if (!act && !run) m_en = addr ? (m_en & ~m) : (m_en | m);
        @(posedge clk); #1;
        reg_wr = 0; ctx_active = 0; ctx_run = 0;
        chk(reg_rdata == {30'd0, m_en}, (act || run) ? "R9 busy write" : "R8 write",
            reg_rdata, {30'd0, m_en});
    endtask

    initial begin
        int br0;
        void'($urandom(32'd1234));
        #12; rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0 && branch_req == 0, "R10 reset outputs", {31'd0, out_valid}, 0);
        chk(reg_rdata == 0, "R8 reset value", reg_rdata, 0);

        // R9: writes blocked while busy
        reg_write(0, 2'b11, 0, 1);
        reg_write(0, 2'b11, 1, 0);
        // R8: set, clear
        reg_write(0, 2'b11, 0, 0);
        reg_write(1, 2'b10, 0, 0);
        reg_write(1, 2'b01, 1, 1);

        // R3: pass-through with strip on
        hdr_mode = 1;
        send_pkt(4, 1, "R3 passthru");
        hdr_mode = 0;

        // R2: strip, short and long packets; R1: two-quadlet packet never frame start
        send_pkt(2, 0, "R2 short");
        send_pkt(5, 0, "R2 strip");
        step(0, 0, 32'h0, "R10 idle");

        // R4: sync bit set, fill mode not buffer fill -> plain strip
        reg_write(0, 2'b10, 0, 0);
        fill_mode = 2'b00;
        send_pkt(4, 0, "R4 sync ignored");

        // R5: discard until frame start
        fill_mode = 2'b01; frame_len = 16'd6;
        step(0, 0, 32'h0, "R10 idle");
        send_pkt(5, 0, "R5 discard");
        send_pkt(4, 0, "R5 discard");
        send_pkt(4, 1, "R5 first sof");       // count = 2
        send_pkt(6, 0, "R6 fill");            // count = 6 -> wraps to 0
        br0 = n_br;
        send_pkt(3, 1, "R6 in place");        // count 0, no branch; count = 1
        chk(n_br == br0, "R6 no branch", n_br, br0);
        send_pkt(4, 1, "R7 out of place");    // branch
        chk(n_br == br0 + 1, "R7 one pulse", n_br, br0 + 1);

        // random phase
        for (int p = 0; p < 1500; p++) begin
            if (p % 25 == 0) begin
                hdr_mode  = ($urandom % 4) == 0;
                fill_mode = 2'($urandom);
                frame_len = 16'(3 + $urandom % 8);
                reg_write($urandom % 2, 2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
            end
            send_pkt(1 + $urandom % 7, $urandom % 2, "R5 random");
            if ($urandom % 3 == 0) step(0, 0, 32'h0, "R10 idle");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule